// File: doc/BRIEF.md
# SPI Chip-Select Timing Controller

This block frames a group of SPI transfer units with an active-low chip select. It makes sure that four programmable gaps, each counted in system clocks, are met around the clock activity. The first gap runs from chip-select assertion to the start of the first unit. The second is a hold period after the last unit so the final data stays stable. The third runs from clock stop to chip-select release. The fourth is a minimum time that chip select stays high before it may assert again. A sequencer asks for a group with `start_req`. The request carries the number of units, a close flag and a chip-select choice. The controller hands each unit to the shift engine with a one-cycle `begin_unit` pulse and waits for `unit_done` before it issues the next one.

When a group ends without the close flag, chip select stays low. The controller then waits for the next group, which begins at once with no setup gap and keeps the chip select already chosen. A stop request never cuts a unit short. It takes effect at the next unit boundary and forces the full closing sequence, whatever the close flag says. A start request that arrives while the controller is closing is held. It begins as soon as the minimum high time has elapsed.

The delay settings live in a 32-bit timing word that is written through `cfg_wr`/`cfg_wdata` and takes effect at the next delay it governs. The interfaces are plain control strobes with no back-pressure. `begin_unit`/`unit_done` form a request/complete pair, so the shift engine throttles the controller by delaying `unit_done`.

Top module: `cs_timing_ctrl`

## Requirements
- R1: After reset, every `cs_n` bit is 1 and `busy` and `begin_unit` are 0. The timing word resets to setup 6, clock-off 4, hold 6 and minimum-high 6 clocks.
- R2: The setup gap is timing word bits [3:0]. On a start from idle, chip select is low for exactly that many cycles before the first `begin_unit`.
- R3: `begin_unit` is a one-cycle pulse. A group of N units gets exactly N pulses, and no pulse is issued while an earlier unit has not yet seen `unit_done`.
- R4: After the cycle in which the last unit's `unit_done` is high, chip select stays low for exactly hold (bits [19:16]) plus clock-off (bits [11:8]) cycles, and then rises.
- R5: After release, chip select stays high for at least the minimum-high value (bits [31:24]). A start arriving during hold, clock-off or minimum-high is held, and chip select is then high for exactly that value before the new setup gap begins.
- R6: With the close flag at 0, chip select stays low and `busy` stays high after the group. A start in this state issues `begin_unit` in the next cycle, with no setup gap, and ignores `cs_select`. A stop in this state runs the closing sequence.
- R7: A stop during setup or a group lets the current unit finish. No further `begin_unit` is issued, and the closing sequence runs even with the close flag at 0.
- R8: `cs_select` 0 drives `cs_n[0]` low and 1 drives `cs_n[1]` low. Codes 2 and 3 assert neither, but the timing still runs. At most one `cs_n` bit is low at any time.
- R9: `busy` is high from the cycle after the accepted start until the minimum-high period completes. While `busy` is 0, all `cs_n` bits are 1.
- R10: A delay field of 0 lasts one cycle.
- R11: `unit_done` with no unit outstanding is ignored, and so is `start_req` during setup or an active group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the timing word |
| cfg_wdata | input | 32 | Timing word: [3:0] setup, [11:8] clock-off, [19:16] hold, [31:24] minimum high |
| cs_select | input | SEL_W | Chip-select choice, captured at a start from idle |
| grp_units | input | UNIT_W | Number of units in the requested group |
| grp_close | input | 1 | Release chip select when the group ends |
| start_req | input | 1 | Group request strobe |
| stop_req | input | 1 | Stop at next unit boundary |
| unit_done | input | 1 | Shift engine finished the outstanding unit |
| begin_unit | output | 1 | One-cycle request to shift one unit |
| cs_n | output | NUM_CS | Active-low chip selects |
| busy | output | 1 | Controller is framing or recovering |

## Verification
The bench builds the block with its defaults: two chip selects, a 2-bit select field and a 16-bit unit count. The two outputs let the bench check both real select codes and the two reserved codes against each other. The 8-bit minimum-high field can be driven to 255 and measured within the run, and the bench also drives every field to 0 to check the one-cycle floor. Groups of one to four units exercise pending starts, stops and open groups at unit boundaries.

// File: rtl/cst_pkg.sv
package cst_pkg;
  localparam int DLY_W = 8;

  localparam logic [DLY_W-1:0] RST_SETUP = 8'd6;
  localparam logic [DLY_W-1:0] RST_OFF   = 8'd4;
  localparam logic [DLY_W-1:0] RST_HOLD  = 8'd6;
  localparam logic [DLY_W-1:0] RST_HIGH  = 8'd6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_OPEN,
    ST_HOLD,
    ST_CLKOFF,
    ST_CSHIGH
  } cst_state_e;
endpackage

// File: rtl/cst_cfg_reg.sv
module cst_cfg_reg
  import cst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [31:0]      wdata,
  output logic [DLY_W-1:0] setup_d,
  output logic [DLY_W-1:0] off_d,
  output logic [DLY_W-1:0] hold_d,
  output logic [DLY_W-1:0] high_d
);
  logic unused_bits;
  assign unused_bits = ^{wdata[7:4], wdata[15:12], wdata[23:20]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_d <= RST_SETUP;
      off_d   <= RST_OFF;
      hold_d  <= RST_HOLD;
      high_d  <= RST_HIGH;
    end else if (wr) begin
      setup_d <= {4'b0, wdata[3:0]};
      off_d   <= {4'b0, wdata[11:8]};
      hold_d  <= {4'b0, wdata[19:16]};
      high_d  <= wdata[31:24];
    end
  end
endmodule

// File: rtl/cst_delay_cnt.sv
module cst_delay_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - W'(1);
  end

  // a period of value D lasts max(D,1) cycles
  assign expired = (cnt_q <= W'(1));
endmodule

// File: rtl/cst_cs_decode.sv
module cst_cs_decode #(
  parameter int NUM_CS = 2,
  parameter int SEL_W  = 2
) (
  input  logic              active,
  input  logic [SEL_W-1:0]  sel,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = ~(active && (sel == SEL_W'(i)));
  end
endmodule

// File: rtl/cs_timing_ctrl.sv
module cs_timing_ctrl
  import cst_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int SEL_W  = 2,
  parameter int UNIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  input  logic [SEL_W-1:0]  cs_select,
  input  logic [UNIT_W-1:0] grp_units,
  input  logic              grp_close,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              unit_done,
  output logic              begin_unit,
  output logic [NUM_CS-1:0] cs_n,
  output logic              busy
);
  logic [DLY_W-1:0] setup_d, off_d, hold_d, high_d;
  logic [DLY_W-1:0] dly_val;
  logic             dly_ld, dly_exp;

  cst_state_e        state_q, nxt;
  logic              inflight_q, close_q, stop_pend_q, pend_q, pend_close_q;
  logic [UNIT_W-1:0] rem_q, pend_units_q;
  logic [SEL_W-1:0]  sel_q, pend_sel_q;

  cst_cfg_reg u_cfg (
    .clk, .rst_n, .wr(cfg_wr), .wdata(cfg_wdata),
    .setup_d, .off_d, .hold_d, .high_d
  );

  cst_delay_cnt #(.W(DLY_W)) u_dly (
    .clk, .rst_n, .load(dly_ld), .load_val(dly_val), .expired(dly_exp)
  );

  logic cs_act;
  assign cs_act = (state_q == ST_SETUP) || (state_q == ST_ACTIVE) ||
                  (state_q == ST_OPEN)  || (state_q == ST_HOLD)   ||
                  (state_q == ST_CLKOFF);

  cst_cs_decode #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_dec (
    .active(cs_act), .sel(sel_q), .cs_n(cs_n)
  );

  logic stop_now, pend_now, grp_end, cshigh_exit, late_phase;
  logic take_live, take_fresh, take_pend, pend_set;

  assign stop_now    = stop_pend_q | stop_req;
  assign pend_now    = pend_q | start_req;
  assign begin_unit  = (state_q == ST_ACTIVE) && !inflight_q && !stop_now &&
                       (rem_q != '0);
  assign grp_end     = (state_q == ST_ACTIVE) && (!inflight_q || unit_done) &&
                       (stop_now || (rem_q == '0));
  assign cshigh_exit = (state_q == ST_CSHIGH) && dly_exp;
  assign late_phase  = (state_q == ST_HOLD) || (state_q == ST_CLKOFF) ||
                       (state_q == ST_CSHIGH);
  assign take_fresh  = start_req && (((state_q == ST_IDLE)) ||
                                     (cshigh_exit && !pend_q));
  assign take_live   = take_fresh || ((state_q == ST_OPEN) && start_req && !stop_req);
  assign take_pend   = cshigh_exit && pend_q;
  assign pend_set    = !pend_q && start_req && late_phase && !cshigh_exit;
  assign busy        = (state_q != ST_IDLE);

  always_comb begin
    nxt     = state_q;
    dly_ld  = 1'b0;
    dly_val = '0;
    unique case (state_q)
      ST_IDLE: if (start_req) begin
        nxt = ST_SETUP; dly_ld = 1'b1; dly_val = setup_d;
      end
      ST_SETUP: if (dly_exp) nxt = ST_ACTIVE;
      ST_ACTIVE: if (grp_end) begin
        if (stop_now || close_q) begin
          nxt = ST_HOLD; dly_ld = 1'b1; dly_val = hold_d;
        end else begin
          nxt = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (stop_req) begin
          nxt = ST_HOLD; dly_ld = 1'b1; dly_val = hold_d;
        end else if (start_req) begin
          nxt = ST_ACTIVE;
        end
      end
      ST_HOLD: if (dly_exp) begin
        nxt = ST_CLKOFF; dly_ld = 1'b1; dly_val = off_d;
      end
      ST_CLKOFF: if (dly_exp) begin
        nxt = ST_CSHIGH; dly_ld = 1'b1; dly_val = high_d;
      end
      ST_CSHIGH: if (dly_exp) begin
        if (pend_now) begin
          nxt = ST_SETUP; dly_ld = 1'b1; dly_val = setup_d;
        end else begin
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      inflight_q   <= 1'b0;
      rem_q        <= '0;
      close_q      <= 1'b0;
      sel_q        <= '0;
      stop_pend_q  <= 1'b0;
      pend_q       <= 1'b0;
      pend_units_q <= '0;
      pend_close_q <= 1'b0;
      pend_sel_q   <= '0;
    end else begin
      state_q <= nxt;

      if (begin_unit)     inflight_q <= 1'b1;
      else if (unit_done) inflight_q <= 1'b0;

      if (take_live) begin
        rem_q   <= grp_units;
        close_q <= grp_close;
      end else if (take_pend) begin
        rem_q   <= pend_units_q;
        close_q <= pend_close_q;
      end else if (begin_unit) begin
        rem_q   <= rem_q - UNIT_W'(1);
      end

      if (take_fresh)     sel_q <= cs_select;
      else if (take_pend) sel_q <= pend_sel_q;

      if (pend_set) begin
        pend_q       <= 1'b1;
        pend_units_q <= grp_units;
        pend_close_q <= grp_close;
        pend_sel_q   <= cs_select;
      end else if (take_pend) begin
        pend_q <= 1'b0;
      end

      if ((state_q == ST_ACTIVE) && (nxt != ST_ACTIVE))
        stop_pend_q <= 1'b0;
      else if (stop_req && ((state_q == ST_SETUP) || (state_q == ST_ACTIVE)))
        stop_pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cst_checker.sv
module cst_checker #(
  parameter int NUM_CS = 2,
  parameter int DLY_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] cs_n,
  input logic              busy,
  input logic              begin_unit,
  input logic              unit_done,
  input logic [DLY_W-1:0]  min_high
);
  logic              allh, seen_low_q, outst_q;
  logic [9:0]        high_cnt_q;
  logic [NUM_CS-1:0] cs_n_q;
  logic [9:0]        min_eff;

  assign allh    = &cs_n;
  assign min_eff = (min_high == '0) ? 10'd1 : 10'(min_high);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_low_q <= 1'b0;
      outst_q    <= 1'b0;
      high_cnt_q <= '0;
      cs_n_q     <= '1;
    end else begin
      seen_low_q <= seen_low_q | !allh;
      cs_n_q     <= cs_n;
      if (begin_unit)     outst_q <= 1'b1;
      else if (unit_done) outst_q <= 1'b0;
      if (!allh)                   high_cnt_q <= '0;
      else if (high_cnt_q != '1)   high_cnt_q <= high_cnt_q + 10'd1;
    end
  end

  // R5: a high period after a low period lasts at least the minimum
  a_r5_min_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!allh && seen_low_q && (high_cnt_q != '0)) |-> (high_cnt_q >= min_eff));

  // R7: chip select never released while a unit is outstanding
  a_r7_no_midunit_release: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cs_n & ~cs_n_q)) |-> !outst_q);

  // R8: never more than one select low
  a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  // R9: idle means all selects released
  a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> allh);

  // R3: single-cycle pulse, and only with nothing outstanding
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    begin_unit |=> !begin_unit);

  a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    begin_unit |-> !outst_q);
endmodule

bind cs_timing_ctrl cst_checker #(.NUM_CS(NUM_CS), .DLY_W(cst_pkg::DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(busy),
  .begin_unit(begin_unit), .unit_done(unit_done), .min_high(high_d)
);

// File: tb/cs_timing_ctrl_tb.sv
module cs_timing_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  cs_select = '0;
  logic [15:0] grp_units = '0;
  logic        grp_close = 1'b0;
  logic        start_req = 1'b0;
  logic        stop_req = 1'b0;
  logic        unit_done = 1'b0;
  logic        begin_unit;
  logic [1:0]  cs_n;
  logic        busy;

  int n_chk = 0;
  int n_fail = 0;
  bit tail_beg;

  always #2 clk = ~clk;

  cs_timing_ctrl u_dut (
    .clk, .rst_n, .cfg_wr, .cfg_wdata, .cs_select, .grp_units, .grp_close,
    .start_req, .stop_req, .unit_done, .begin_unit, .cs_n, .busy
  );

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [31:0] w);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_wr = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic xfer_start(input logic [1:0] sel, input int units, input bit close);
    @(negedge clk);
    cs_select = sel; grp_units = 16'(units); grp_close = close; start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic body(input int exp_setup, input int units, input int ulat,
                      input bit poke, input logic [1:0] exp_csn, input string tag);
    int cnt;
    int nb;
    bit bad;
    chk(busy === 1'b1, {tag, " R9 busy after start"}, int'(busy), 1);
    chk(cs_n === exp_csn, {tag, " R8 select pattern"}, int'(cs_n), int'(exp_csn));
    cnt = 0;
    while (!begin_unit && cnt < 100) begin
      if (poke && cnt == 0) unit_done = 1'b1;
      @(negedge clk);
      unit_done = 1'b0;
      cnt++;
    end
    chk(cnt == exp_setup, {tag, " R2 setup cycles"}, cnt, exp_setup);
    bad = 1'b0; nb = 0;
    for (int u = 0; u < units; u++) begin
      if (begin_unit) nb++;
      for (int w = 0; w < ulat; w++) begin
        @(negedge clk);
        start_req = poke && (u == 0) && (w == 0);
        if (begin_unit) bad = 1'b1;
      end
      start_req = 1'b0;
      unit_done = 1'b1;
      @(negedge clk);
      unit_done = 1'b0;
    end
    chk(nb == units, {tag, " R3 unit pulses"}, nb, units);
    chk(!bad, {tag, " R3 no pulse while outstanding"}, int'(bad), 0);
    chk(!begin_unit, {tag, " R3 no pulse beyond count"}, int'(begin_unit), 0);
  endtask

  task automatic tail(input int exp_tail, input string tag);
    int t;
    t = 0; tail_beg = 1'b0;
    while (cs_n !== 2'b11 && t < 1000) begin
      if (begin_unit) tail_beg = 1'b1;
      t++;
      @(negedge clk);
    end
    chk(t == exp_tail, {tag, " R4 closing low cycles"}, t, exp_tail);
  endtask

  task automatic high(input int exp_high, input string tag);
    int h;
    h = 0;
    while (busy && cs_n === 2'b11 && h < 1000) begin
      h++;
      @(negedge clk);
    end
    chk(h == exp_high, {tag, " R5 high cycles"}, h, exp_high);
    chk(busy === 1'b0, {tag, " R9 busy clears"}, int'(busy), 0);
  endtask

  task automatic t_reset;
    bit bad;
    chk(cs_n === 2'b11 && !busy && !begin_unit, "R1 reset outputs",
        int'({cs_n, busy, begin_unit}), 12);
    unit_done = 1'b1;
    @(negedge clk); unit_done = 1'b0;
    bad = 1'b0;
    repeat (3) begin
      if (cs_n !== 2'b11 || busy || begin_unit) bad = 1'b1;
      @(negedge clk);
    end
    chk(!bad, "R11 stray unit_done in idle", int'(bad), 0);
  endtask

  task automatic t_default;
    xfer_start(2'd0, 3, 1'b1);
    body(6, 3, 3, 1'b0, 2'b10, "R1 default");
    tail(10, "R1 default");
    high(6, "R1 default");
  endtask

  task automatic t_pending;
    int h;
    bit bad;
    wr_cfg(32'h0905_0203);
    xfer_start(2'd1, 2, 1'b1);
    body(3, 2, 2, 1'b0, 2'b01, "R4 custom");
    tail(7, "R4 custom");
    cs_select = 2'd0; grp_units = 16'd1; grp_close = 1'b1; start_req = 1'b1;
    h = 0; bad = 1'b0;
    while (cs_n === 2'b11 && h < 100) begin
      h++;
      if (!busy) bad = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
    end
    chk(h == 9, "R5 pending start high time", h, 9);
    chk(!bad, "R9 busy through pending gap", int'(bad), 0);
    body(3, 1, 2, 1'b0, 2'b10, "R5 pending");
    tail(7, "R5 pending");
    high(9, "R5 pending");
  endtask

  task automatic t_open;
    bit bad;
    xfer_start(2'd0, 2, 1'b0);
    body(3, 2, 2, 1'b0, 2'b10, "R6 open");
    bad = 1'b0;
    repeat (5) begin
      if (cs_n !== 2'b10 || !busy || begin_unit) bad = 1'b1;
      @(negedge clk);
    end
    chk(!bad, "R6 select held low between groups", int'(bad), 0);
    xfer_start(2'd1, 1, 1'b1);
    body(0, 1, 2, 1'b0, 2'b10, "R6 continue");
    tail(7, "R6 continue");
    high(9, "R6 continue");
    xfer_start(2'd0, 1, 1'b0);
    body(3, 1, 2, 1'b0, 2'b10, "R6 stop open");
    repeat (3) @(negedge clk);
    chk(cs_n === 2'b10, "R6 still open before stop", int'(cs_n), 2);
    stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    tail(7, "R6 stop open");
    high(9, "R6 stop open");
  endtask

  task automatic t_stop;
    int cnt;
    xfer_start(2'd0, 4, 1'b0);
    cnt = 0;
    while (!begin_unit && cnt < 100) begin
      @(negedge clk); cnt++;
    end
    chk(cnt == 3, "R7 setup before stop", cnt, 3);
    @(negedge clk); stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    chk(cs_n === 2'b10, "R7 unit not cut short", int'(cs_n), 2);
    @(negedge clk); unit_done = 1'b1;
    @(negedge clk); unit_done = 1'b0;
    chk(!begin_unit, "R7 no unit after stop", int'(begin_unit), 0);
    tail(7, "R7 stop");
    chk(!tail_beg, "R7 no unit during close", int'(tail_beg), 0);
    high(9, "R7 stop");
  endtask

  task automatic t_reserved;
    int n;
    bit bad;
    xfer_start(2'd2, 1, 1'b1);
    body(3, 1, 2, 1'b0, 2'b11, "R8 reserved");
    n = 0; bad = 1'b0;
    while (busy && n < 1000) begin
      if (cs_n !== 2'b11) bad = 1'b1;
      n++;
      @(negedge clk);
    end
    chk(n == 16, "R8 reserved code timing", n, 16);
    chk(!bad, "R8 reserved code asserts nothing", int'(bad), 0);
  endtask

  task automatic t_zero;
    wr_cfg(32'h0000_0000);
    xfer_start(2'd0, 1, 1'b1);
    body(1, 1, 2, 1'b0, 2'b10, "R10 zero");
    tail(2, "R10 zero");
    high(1, "R10 zero");
  endtask

  task automatic t_ignore;
    wr_cfg(32'h0905_0203);
    xfer_start(2'd0, 2, 1'b1);
    body(3, 2, 3, 1'b1, 2'b10, "R11 stray strobes");
    tail(7, "R11 stray strobes");
    high(9, "R11 stray strobes");
  endtask

  task automatic t_max;
    wr_cfg(32'hFF0F_0F0F);
    repeat (300) @(negedge clk);
    xfer_start(2'd1, 1, 1'b1);
    body(15, 1, 2, 1'b0, 2'b01, "R2 max");
    tail(30, "R4 max");
    high(255, "R5 max");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default();
    t_pending();
    t_open();
    t_stop();
    t_reserved();
    t_zero();
    t_ignore();
    t_max();
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule